// File: doc/BRIEF.md
# PTP Event Timestamp Classifier

This block sits behind a receive header parser and decides, once per packet, whether the packet is a precision-time event that must be timestamped. The parser presents each header field with its own strobe. The block keeps those fields for the current packet. When the end-of-header strobe arrives, it checks the transport match and the message match and raises a one-cycle timestamp request.

The transport match can be an Ethernet frame that carries the 1588 EtherType, a UDP datagram sent to the event port, or either of the two, depending on the mode. The message match either compares the message type with one configured code (Sync or Delay_Req) or, in the all-events version 2 mode, accepts any event message. The configuration word holds the expected code in its low nibble and the UDP event port in its upper 16 bits. Both the mode and the configuration word are sampled in the end-of-header cycle.

Top module: `tsreq_classifier`

## Requirements
- R1: The UDP hit needs a captured IP protocol of 17 and a captured destination port equal to `cfg_match[31:16]`. That port is 319 (0x013F) in normal use, and any other port, or any other protocol, gives no UDP hit.
- R2: The Ethernet hit needs a captured EtherType of 0x88F7.
- R3: Mode 1 (version 1, UDP only) requests a timestamp only on a UDP hit with version 1 and a message type equal to `cfg_match[3:0]`. An Ethernet hit alone does not count.
- R4: Mode 2 (version 2, one message) requests on an Ethernet hit or a UDP hit with version 2 and a message type equal to `cfg_match[3:0]`.
- R5: In modes 1 and 2, only configured codes 0 (Sync) and 1 (Delay_Req) can match. Any other configured code never produces a request.
- R6: Mode 3 (all version 2 events) requests on an Ethernet hit or a UDP hit with version 2 and any message type from 0 to 3. Types 4 and above are rejected.
- R7: Mode 0 (disabled) and modes 4 to 7 (unsupported, including any request to stamp every packet) never request a timestamp.
- R8: A field counts only if its strobe has fired since the last `pkt_sof`. A strobe in the same cycle as `hdr_end` counts. A strobe in the same cycle as `pkt_sof` belongs to the new packet.
- R9: `ts_req` is high for exactly the one cycle after a qualifying `hdr_end`.
- R10: At most one request per packet. Any further `hdr_end` before the next `pkt_sof` is ignored.
- R11: During and after reset, `ts_req` is low and no field is held as captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Match mode: 0 off, 1 v1 UDP, 2 v2 one message, 3 v2 all events, 4-7 unsupported |
| cfg_match | input | 32 | [3:0] expected message code, [31:16] UDP event port |
| pkt_sof | input | 1 | Start of a new packet; clears captured fields |
| eth_type | input | 16 | EtherType value |
| eth_type_vld | input | 1 | EtherType strobe |
| ip_proto | input | 8 | IP protocol number |
| ip_proto_vld | input | 1 | IP protocol strobe |
| udp_dport | input | 16 | UDP destination port |
| udp_dport_vld | input | 1 | UDP port strobe |
| ptp_ver | input | 4 | PTP version number |
| ptp_ver_vld | input | 1 | Version strobe |
| ptp_msg | input | 4 | PTP message type |
| ptp_msg_vld | input | 1 | Message type strobe |
| hdr_end | input | 1 | End-of-header strobe; the decision is taken here |
| ts_req | output | 1 | One-cycle timestamp request |

## Verification
Two things can happen in the same cycle: the last field strobe, which loads the capture, and the end-of-header strobe, which takes the decision. The bench provokes this by strobing the message type together with `hdr_end`, and it expects a request from this packet's own message type. A second test sends a packet whose EtherType strobe is missing, right after a packet that did strobe the 1588 EtherType, and it expects no request; this shows that `pkt_sof` clears the fields left over from the earlier packet. A third test sends a repeated `hdr_end` with no new start and expects it to stay silent.

// File: rtl/tsc_pkg.sv
// Package: constants shared by the timestamp classifier.
// Assumes the mode encoding below is also used by the configuration source.
package tsc_pkg;
    localparam logic [2:0]  MODE_OFF      = 3'd0;
    localparam logic [2:0]  MODE_V1_UDP   = 3'd1;
    localparam logic [2:0]  MODE_V2_ONE   = 3'd2;
    localparam logic [2:0]  MODE_V2_EVENT = 3'd3;
    localparam logic [15:0] ETYPE_1588    = 16'h88F7;
    localparam logic [7:0]  IPPROTO_UDP   = 8'd17;
    localparam int unsigned PTP_V1        = 1;
    localparam int unsigned PTP_V2        = 2;
    localparam int unsigned EVENT_MSG_MAX = 3;
endpackage

// File: rtl/tsc_field_reg.sv
// Per-packet field holder.
// Loads the value on its strobe and forgets it on start-of-packet.
// The outputs forward a strobe that fires in the current cycle, so a
// decision taken in that same cycle already sees the new value.
// If the load and the clear fall in the same cycle, the load wins
// (the field belongs to the new packet).
module tsc_field_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] val,
    output logic         vld
);
    logic [W-1:0] q_r;
    logic         v_r;

    // Purpose: hold the last strobed value and its present flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
            v_r <= 1'b0;
        end else if (ld) begin
            q_r <= d;
            v_r <= 1'b1;
        end else if (clr) begin
            q_r <= '0;
            v_r <= 1'b0;
        end
    end

    // Purpose: forward a same-cycle strobe past the register.
    always_comb begin
        val = ld ? d : q_r;
        vld = ld | (v_r & ~clr);
    end
endmodule

// File: rtl/tsc_proto_match.sv
// Transport matcher: decides whether the packet is a 1588 Ethernet frame
// and/or a UDP datagram to the configured event port.
// Assumes its inputs are the forwarded per-packet fields.
module tsc_proto_match #(
    parameter int ET_W    = 16,
    parameter int PROTO_W = 8,
    parameter int PORT_W  = 16
) (
    input  logic [ET_W-1:0]    et_val,
    input  logic               et_vld,
    input  logic [PROTO_W-1:0] proto_val,
    input  logic               proto_vld,
    input  logic [PORT_W-1:0]  dport_val,
    input  logic               dport_vld,
    input  logic [PORT_W-1:0]  event_port,
    output logic               l2_hit,
    output logic               l4_hit
);
    import tsc_pkg::*;

    localparam logic [ET_W-1:0]    ET_MATCH = ET_W'(ETYPE_1588);
    localparam logic [PROTO_W-1:0] UDP_NUM  = PROTO_W'(IPPROTO_UDP);

    // Purpose: compare captured fields against the fixed and configured keys.
    always_comb begin
        l2_hit = et_vld && (et_val == ET_MATCH);
        l4_hit = proto_vld && (proto_val == UDP_NUM) &&
                 dport_vld && (dport_val == event_port);
    end
endmodule

// File: rtl/tsc_msg_match.sv
// Message matcher: combines the transport hits with the version and
// message-type rules of the selected mode.
// Assumes an unlisted mode value must stay silent.
module tsc_msg_match #(
    parameter int VER_W = 4,
    parameter int MSG_W = 4
) (
    input  logic [2:0]       mode,
    input  logic [MSG_W-1:0] code,
    input  logic             l2_hit,
    input  logic             l4_hit,
    input  logic [VER_W-1:0] ver_val,
    input  logic             ver_vld,
    input  logic [MSG_W-1:0] msg_val,
    input  logic             msg_vld,
    output logic             hit
);
    import tsc_pkg::*;

    localparam logic [VER_W-1:0] V1  = VER_W'(PTP_V1);
    localparam logic [VER_W-1:0] V2  = VER_W'(PTP_V2);
    localparam logic [MSG_W-1:0] EVT = MSG_W'(EVENT_MSG_MAX);

    logic code_ok;
    logic msg_eq;
    logic is_v1;
    logic is_v2;

    // Purpose: shared qualifiers for every mode.
    always_comb begin
        code_ok = (code[MSG_W-1:1] == '0);
        msg_eq  = msg_vld && (msg_val == code);
        is_v1   = ver_vld && (ver_val == V1);
        is_v2   = ver_vld && (ver_val == V2);
    end

    // Purpose: select the rule set that the mode calls for.
    always_comb begin
        case (mode)
            MODE_V1_UDP:   hit = l4_hit && is_v1 && msg_eq && code_ok;
            MODE_V2_ONE:   hit = (l2_hit || l4_hit) && is_v2 && msg_eq && code_ok;
            MODE_V2_EVENT: hit = (l2_hit || l4_hit) && is_v2 && msg_vld && (msg_val <= EVT);
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsreq_classifier.sv
// Top: per-packet PTP event classifier.
// Captures the strobed header fields of the current packet and, on the
// end-of-header strobe, registers a single-cycle timestamp request.
// Assumes pkt_sof marks each packet before its fields arrive; cfg is
// sampled in the hdr_end cycle.
module tsreq_classifier #(
    parameter int ET_W    = 16,
    parameter int PROTO_W = 8,
    parameter int PORT_W  = 16,
    parameter int VER_W   = 4,
    parameter int MSG_W   = 4,
    parameter int CFG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_mode,
    input  logic [CFG_W-1:0]   cfg_match,
    input  logic               pkt_sof,
    input  logic [ET_W-1:0]    eth_type,
    input  logic               eth_type_vld,
    input  logic [PROTO_W-1:0] ip_proto,
    input  logic               ip_proto_vld,
    input  logic [PORT_W-1:0]  udp_dport,
    input  logic               udp_dport_vld,
    input  logic [VER_W-1:0]   ptp_ver,
    input  logic               ptp_ver_vld,
    input  logic [MSG_W-1:0]   ptp_msg,
    input  logic               ptp_msg_vld,
    input  logic               hdr_end,
    output logic               ts_req
);
    localparam int PORT_LSB = CFG_W - PORT_W;

    logic [ET_W-1:0]    et_val;
    logic               et_vld;
    logic [PROTO_W-1:0] proto_val;
    logic               proto_vld;
    logic [PORT_W-1:0]  dport_val;
    logic               dport_vld;
    logic [VER_W-1:0]   ver_val;
    logic               ver_vld;
    logic [MSG_W-1:0]   msg_val;
    logic               msg_vld;
    logic               l2_hit;
    logic               l4_hit;
    logic               pkt_hit;
    logic               pkt_done_q;
    logic               ts_req_q;

    tsc_field_reg #(.W(ET_W)) u_et (
        .clk(clk), .rst_n(rst_n), .clr(pkt_sof), .ld(eth_type_vld),
        .d(eth_type), .val(et_val), .vld(et_vld));
    tsc_field_reg #(.W(PROTO_W)) u_proto (
        .clk(clk), .rst_n(rst_n), .clr(pkt_sof), .ld(ip_proto_vld),
        .d(ip_proto), .val(proto_val), .vld(proto_vld));
    tsc_field_reg #(.W(PORT_W)) u_dport (
        .clk(clk), .rst_n(rst_n), .clr(pkt_sof), .ld(udp_dport_vld),
        .d(udp_dport), .val(dport_val), .vld(dport_vld));
    tsc_field_reg #(.W(VER_W)) u_ver (
        .clk(clk), .rst_n(rst_n), .clr(pkt_sof), .ld(ptp_ver_vld),
        .d(ptp_ver), .val(ver_val), .vld(ver_vld));
    tsc_field_reg #(.W(MSG_W)) u_msg (
        .clk(clk), .rst_n(rst_n), .clr(pkt_sof), .ld(ptp_msg_vld),
        .d(ptp_msg), .val(msg_val), .vld(msg_vld));

    tsc_proto_match #(.ET_W(ET_W), .PROTO_W(PROTO_W), .PORT_W(PORT_W)) u_proto_match (
        .et_val(et_val), .et_vld(et_vld),
        .proto_val(proto_val), .proto_vld(proto_vld),
        .dport_val(dport_val), .dport_vld(dport_vld),
        .event_port(cfg_match[PORT_LSB +: PORT_W]),
        .l2_hit(l2_hit), .l4_hit(l4_hit));

    tsc_msg_match #(.VER_W(VER_W), .MSG_W(MSG_W)) u_msg_match (
        .mode(cfg_mode), .code(cfg_match[MSG_W-1:0]),
        .l2_hit(l2_hit), .l4_hit(l4_hit),
        .ver_val(ver_val), .ver_vld(ver_vld),
        .msg_val(msg_val), .msg_vld(msg_vld),
        .hit(pkt_hit));

    // Purpose: remember that this packet's decision has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       pkt_done_q <= 1'b0;
        else if (pkt_sof) pkt_done_q <= hdr_end;
        else if (hdr_end) pkt_done_q <= 1'b1;
    end

    // Purpose: register one request per packet on a qualifying header end.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_req_q <= 1'b0;
        else        ts_req_q <= hdr_end && (pkt_sof || !pkt_done_q) && pkt_hit;
    end

    assign ts_req = ts_req_q;
endmodule

// File: rtl/tsreq_classifier_chk.sv
// Checker: temporal properties of the classifier, bound into the top.
module tsreq_classifier_chk #(
    parameter int MSG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cfg_mode,
    input logic             pkt_sof,
    input logic             hdr_end,
    input logic             l4_hit,
    input logic [MSG_W-1:0] msg_val,
    input logic             msg_vld,
    input logic             pkt_done_q,
    input logic             ts_req
);
    // R9: a request only ever follows a header end
    p_req_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ts_req |-> $past(hdr_end));

    // R10: a repeated header end within one packet stays silent
    p_one_per_packet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_end && pkt_done_q && !pkt_sof) |=> !ts_req);

    // R7: the disabled and unsupported modes never request
    p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_end && (cfg_mode == 3'd0 || cfg_mode >= 3'd4)) |=> !ts_req);

    // R3: version 1 needs the UDP path
    p_v1_needs_udp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_end && cfg_mode == 3'd1 && !l4_hit) |=> !ts_req);

    // R6: only event codes pass in all-events mode
    p_event_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_end && cfg_mode == 3'd3 && msg_vld && msg_val > MSG_W'(3)) |=> !ts_req);
endmodule

bind tsreq_classifier tsreq_classifier_chk #(.MSG_W(MSG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .pkt_sof(pkt_sof),
    .hdr_end(hdr_end), .l4_hit(l4_hit), .msg_val(msg_val), .msg_vld(msg_vld),
    .pkt_done_q(pkt_done_q), .ts_req(ts_req));

// File: tb/tsreq_classifier_tb.sv
module tsreq_classifier_tb;
    typedef struct packed {
        logic [2:0]  mode;
        logic [3:0]  code;
        logic [15:0] port;
        logic [15:0] et;   logic et_v;
        logic [7:0]  pr;   logic pr_v;
        logic [15:0] dp;   logic dp_v;
        logic [3:0]  ver;  logic ver_v;
        logic [3:0]  msg;  logic msg_v;
        logic        exp;
        logic [7:0]  rq;
    } vec_t;

    localparam logic        T  = 1'b1;
    localparam logic        F  = 1'b0;
    localparam logic [15:0] P  = 16'h013F;
    localparam logic [15:0] PX = 16'h0140;
    localparam logic [15:0] IP = 16'h0800;
    localparam logic [15:0] E  = 16'h88F7;
    localparam logic [7:0]  U  = 8'd17;
    localparam logic [7:0]  TC = 8'd6;
    localparam logic [7:0]  N8 = 8'd0;
    localparam logic [15:0] Z  = 16'd0;
    localparam int NV = 20;

    localparam vec_t VEC [NV] = '{
        '{3'd1,4'd0,P, IP,T,U,T,P,T,   4'd1,T,4'd0,T, T,8'd3},  // R3 v1 Sync over UDP
        '{3'd1,4'd1,P, IP,T,U,T,P,T,   4'd1,T,4'd1,T, T,8'd3},  // R3 v1 Delay_Req
        '{3'd1,4'd0,P, IP,T,U,T,P,T,   4'd1,T,4'd1,T, F,8'd3},  // R3 wrong message
        '{3'd1,4'd0,P, E,T,N8,F,Z,F,   4'd1,T,4'd0,T, F,8'd3},  // R3 Ethernet not used in v1
        '{3'd1,4'd0,P, IP,T,U,T,PX,T,  4'd1,T,4'd0,T, F,8'd1},  // R1 port 320
        '{3'd1,4'd0,P, IP,T,TC,T,P,T,  4'd1,T,4'd0,T, F,8'd1},  // R1 not UDP
        '{3'd2,4'd0,P, E,T,N8,F,Z,F,   4'd2,T,4'd0,T, T,8'd2},  // R2 R4 Ethernet Sync
        '{3'd2,4'd1,P, IP,T,U,T,P,T,   4'd2,T,4'd1,T, T,8'd4},  // R4 UDP Delay_Req
        '{3'd2,4'd1,P, E,T,N8,F,Z,F,   4'd2,T,4'd0,T, F,8'd4},  // R4 wrong message
        '{3'd2,4'd0,P, IP,T,U,T,P,T,   4'd1,T,4'd0,T, F,8'd4},  // R4 wrong version
        '{3'd2,4'd2,P, E,T,N8,F,Z,F,   4'd2,T,4'd2,T, F,8'd5},  // R5 code 2 refused
        '{3'd3,4'd0,P, E,T,N8,F,Z,F,   4'd2,T,4'd3,T, T,8'd6},  // R6 event 3 Ethernet
        '{3'd3,4'd0,P, IP,T,U,T,P,T,   4'd2,T,4'd2,T, T,8'd6},  // R6 event 2 UDP
        '{3'd3,4'd0,P, E,T,N8,F,Z,F,   4'd2,T,4'd8,T, F,8'd6},  // R6 general message
        '{3'd3,4'd0,P, IP,T,TC,T,P,T,  4'd2,T,4'd0,T, F,8'd6},  // R6 no transport hit
        '{3'd0,4'd0,P, E,T,N8,F,Z,F,   4'd2,T,4'd0,T, F,8'd7},  // R7 disabled
        '{3'd7,4'd0,P, E,T,N8,F,Z,F,   4'd2,T,4'd0,T, F,8'd7},  // R7 unsupported
        '{3'd3,4'd0,P, E,F,N8,F,Z,F,   4'd2,T,4'd0,T, F,8'd8},  // R8 stale EtherType cleared
        '{3'd1,4'd0,PX,IP,T,U,T,PX,T,  4'd1,T,4'd0,T, T,8'd1},  // R1 configured port
        '{3'd1,4'd5,P, IP,T,U,T,P,T,   4'd1,T,4'd5,T, F,8'd5}   // R5 code 5 refused
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [31:0] cfg_match = '0;
    logic        pkt_sof = 1'b0;
    logic [15:0] eth_type = '0;
    logic        eth_type_vld = 1'b0;
    logic [7:0]  ip_proto = '0;
    logic        ip_proto_vld = 1'b0;
    logic [15:0] udp_dport = '0;
    logic        udp_dport_vld = 1'b0;
    logic [3:0]  ptp_ver = '0;
    logic        ptp_ver_vld = 1'b0;
    logic [3:0]  ptp_msg = '0;
    logic        ptp_msg_vld = 1'b0;
    logic        hdr_end = 1'b0;
    logic        ts_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tsreq_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_match(cfg_match),
        .pkt_sof(pkt_sof), .eth_type(eth_type), .eth_type_vld(eth_type_vld),
        .ip_proto(ip_proto), .ip_proto_vld(ip_proto_vld),
        .udp_dport(udp_dport), .udp_dport_vld(udp_dport_vld),
        .ptp_ver(ptp_ver), .ptp_ver_vld(ptp_ver_vld),
        .ptp_msg(ptp_msg), .ptp_msg_vld(ptp_msg_vld),
        .hdr_end(hdr_end), .ts_req(ts_req));

    task automatic check(input string rq, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ts_req=%b expected %b", rq, act, exp);
        end
    endtask

    task automatic drop_strobes();
        pkt_sof = 1'b0; eth_type_vld = 1'b0; ip_proto_vld = 1'b0;
        udp_dport_vld = 1'b0; ptp_ver_vld = 1'b0; ptp_msg_vld = 1'b0;
        hdr_end = 1'b0;
    endtask

    // sof, one cycle of field strobes, hdr_end, then sample the pulse and its end
    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        cfg_mode = v.mode;
        cfg_match = {v.port, 12'd0, v.code};
        pkt_sof = 1'b1;
        @(negedge clk);
        pkt_sof = 1'b0;
        eth_type = v.et;    eth_type_vld = v.et_v;
        ip_proto = v.pr;    ip_proto_vld = v.pr_v;
        udp_dport = v.dp;   udp_dport_vld = v.dp_v;
        ptp_ver = v.ver;    ptp_ver_vld = v.ver_v;
        ptp_msg = v.msg;    ptp_msg_vld = v.msg_v;
        @(negedge clk);
        drop_strobes();
        hdr_end = 1'b1;
        @(negedge clk);
        hdr_end = 1'b0;
        check($sformatf("R%0d vector %0d", v.rq, idx), ts_req, v.exp);
        @(negedge clk);
        check($sformatf("R9 vector %0d pulse end", idx), ts_req, 1'b0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 in reset", ts_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", ts_req, 1'b0);
        // R11: no captured fields after reset, header end alone must not match
        cfg_mode = 3'd3;
        hdr_end = 1'b1;
        @(negedge clk);
        hdr_end = 1'b0;
        check("R11 empty capture", ts_req, 1'b0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R8: message strobe in the hdr_end cycle is used
        @(negedge clk);
        cfg_mode = 3'd3; cfg_match = {P, 16'd0};
        pkt_sof = 1'b1;
        @(negedge clk);
        pkt_sof = 1'b0;
        eth_type = E; eth_type_vld = 1'b1; ptp_ver = 4'd2; ptp_ver_vld = 1'b1;
        @(negedge clk);
        drop_strobes();
        ptp_msg = 4'd1; ptp_msg_vld = 1'b1; hdr_end = 1'b1;
        @(negedge clk);
        drop_strobes();
        check("R8 same-cycle message", ts_req, 1'b1);

        // R10: second header end without a new start is ignored
        hdr_end = 1'b1;
        @(negedge clk);
        hdr_end = 1'b0;
        check("R10 repeated header end", ts_req, 1'b0);

        // R8: same-cycle message with a non-event code rejects
        @(negedge clk);
        pkt_sof = 1'b1;
        @(negedge clk);
        pkt_sof = 1'b0;
        eth_type_vld = 1'b1; ptp_ver_vld = 1'b1;
        @(negedge clk);
        drop_strobes();
        ptp_msg = 4'd9; ptp_msg_vld = 1'b1; hdr_end = 1'b1;
        @(negedge clk);
        drop_strobes();
        check("R8 same-cycle non-event message", ts_req, 1'b0);

        // R10: start and header end together open a new packet and decide it
        pkt_sof = 1'b1; eth_type_vld = 1'b1; ptp_ver_vld = 1'b1;
        ptp_msg = 4'd0; ptp_msg_vld = 1'b1; hdr_end = 1'b1;
        @(negedge clk);
        drop_strobes();
        check("R10 new packet after sof", ts_req, 1'b1);
        @(negedge clk);
        check("R9 pulse ends", ts_req, 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule